// File: doc/BRIEF.md
# Three-State Power Mode Controller

This block sequences a subsystem between three power modes: Run, Idle and Sleep. Each mode drives a fixed pair of enables. Run leaves the clock free and the power on. Idle gates the clock only. Sleep gates the clock and also shuts the block's power off. Software asks for Idle or Sleep with single-cycle request pulses. Idle is left when an interrupt arrives. Sleep is left only on a wake-up event, and Sleep can be entered from Run or from Idle.

Mode changes are not instantaneous. Each kind of move has its own latency, given as a cycle count: Run to Idle, Idle to Run, entry into Sleep, and the return from Sleep. The return from Sleep is by far the longest. While a move is under way a busy flag is high and any new request is dropped. The clock and power enables are applied in a safe order. On entry to Sleep the clock is gated before the power goes off. On wake-up the power comes back first, and the clock is released only when the wake latency has run out.

Three saturating counters record how many cycles the block spends settled in each mode, so that firmware can estimate energy. They are read through a small address/data port.

Top module: `pmode_ctrl`

## Requirements
- R1: While reset is asserted, mode_o is 0 (Run), busy_o, clk_gate_o and pwr_off_o are 0, and every residency counter is 0.
- R2: When a mode is settled (busy_o low), the enables are as follows. Run (mode_o=0) has clk_gate_o=0 and pwr_off_o=0. Idle (mode_o=1) has clk_gate_o=1 and pwr_off_o=0. Sleep (mode_o=2) has clk_gate_o=1 and pwr_off_o=1.
- R3: In settled Run, a sleep_req_i pulse takes priority over an idle_req_i pulse. From the next cycle, mode_o shows the destination mode and busy_o stays high for exactly the latency of that move before the destination is settled. mode_o never changes while busy_o is low in both the current and the previous cycle.
- R4: While busy_o is high, all requests, interrupts and wake-up events are ignored. The exception is the interrupt of R9. In settled Idle an idle_req_i is ignored, and in settled Run irq_i and wake_i are ignored.
- R5: In settled Idle, irq_i starts a move to Run lasting IDLE_RUN_LAT cycles. It takes priority over a sleep_req_i that arrives in the same cycle.
- R6: Settled Sleep is left only on wake_i, which starts a move to Run lasting SLEEP_EXIT_LAT cycles. In settled Sleep, irq_i, idle_req_i and sleep_req_i have no effect.
- R7: During entry into Sleep, clk_gate_o is 1 from the first busy cycle, and pwr_off_o stays 0 until Sleep is settled.
- R8: During the wake from Sleep, pwr_off_o is 0 from the first busy cycle, and clk_gate_o stays 1 until Run is settled.
- R9: If irq_i is high in any cycle of the move from Run to Idle, the controller does not settle in Idle. It continues straight into the move back to Run, and busy_o stays high for RUN_IDLE_LAT+IDLE_RUN_LAT cycles in total.
- R10: Each residency counter adds 1 for each cycle its mode is settled. It does not count cycles in which busy_o is high, and it saturates at 2^CNT_W-1.
- R11: rd_data_o returns the Run counter when rd_addr_i is 0, the Idle counter when it is 1, the Sleep counter when it is 2, and zero when it is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| idle_req_i | input | 1 | Request to enter Idle |
| sleep_req_i | input | 1 | Request to enter Sleep |
| irq_i | input | 1 | Interrupt; ends Idle |
| wake_i | input | 1 | Wake-up event; ends Sleep |
| rd_addr_i | input | 2 | Residency counter select |
| clk_gate_o | output | 1 | Clock gate enable |
| pwr_off_o | output | 1 | Block power shutdown enable |
| busy_o | output | 1 | Mode change in progress |
| mode_o | output | 2 | Settled or destination mode: 0 Run, 1 Idle, 2 Sleep |
| rd_data_o | output | CNT_W | Selected residency counter |

## Verification
A wrong internal state shows up at the enable ports or at busy_o within one cycle of the edge where it arises. Examples are a transition that settles in the wrong mode or a timer loaded with the wrong latency. An enable pair that does not match mode_o is caught at once. A latency that is off by one is caught on the cycle busy_o falls. A lost latched interrupt only shows at the end of Idle entry, when the controller settles in Idle instead of moving on to Run. It also shows later as growth in the Idle residency counter. Counter faults appear on rd_data_o on the next read of the affected address.

// File: rtl/pmode_pkg.sv
package pmode_pkg;
  typedef enum logic [2:0] {
    ST_RUN, ST_IDLE, ST_SLEEP, ST_R2I, ST_I2R, ST_TO_SLP, ST_WAKE
  } pm_state_e;

  localparam logic [1:0] MODE_RUN   = 2'd0;
  localparam logic [1:0] MODE_IDLE  = 2'd1;
  localparam logic [1:0] MODE_SLEEP = 2'd2;
  localparam int unsigned NUM_MODES = 3;
endpackage

// File: rtl/pmode_lat_timer.sv
module pmode_lat_timer #(
  parameter int unsigned LAT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LAT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/pmode_fsm.sv
module pmode_fsm
  import pmode_pkg::*;
#(
  parameter int unsigned LAT_W          = 8,
  parameter int unsigned RUN_IDLE_LAT   = 4,
  parameter int unsigned IDLE_RUN_LAT   = 4,
  parameter int unsigned SLEEP_ENTRY_LAT = 8,
  parameter int unsigned SLEEP_EXIT_LAT  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_req_i,
  input  logic             sleep_req_i,
  input  logic             irq_i,
  input  logic             wake_i,
  input  logic             tmr_done_i,
  output logic             tmr_load_o,
  output logic [LAT_W-1:0] tmr_val_o,
  output pm_state_e        state_o
);
  localparam logic [LAT_W-1:0] LD_RI = LAT_W'(RUN_IDLE_LAT - 1);
  localparam logic [LAT_W-1:0] LD_IR = LAT_W'(IDLE_RUN_LAT - 1);
  localparam logic [LAT_W-1:0] LD_SE = LAT_W'(SLEEP_ENTRY_LAT - 1);
  localparam logic [LAT_W-1:0] LD_SX = LAT_W'(SLEEP_EXIT_LAT - 1);

  pm_state_e state_q, state_d;
  logic      irq_pend_q;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (state_q)
      ST_RUN: begin
        if (sleep_req_i) begin
          state_d = ST_TO_SLP; tmr_load_o = 1'b1; tmr_val_o = LD_SE;
        end else if (idle_req_i) begin
          state_d = ST_R2I; tmr_load_o = 1'b1; tmr_val_o = LD_RI;
        end
      end
      ST_IDLE: begin
        if (irq_i) begin
          state_d = ST_I2R; tmr_load_o = 1'b1; tmr_val_o = LD_IR;
        end else if (sleep_req_i) begin
          state_d = ST_TO_SLP; tmr_load_o = 1'b1; tmr_val_o = LD_SE;
        end
      end
      ST_SLEEP: begin
        if (wake_i) begin
          state_d = ST_WAKE; tmr_load_o = 1'b1; tmr_val_o = LD_SX;
        end
      end
      ST_R2I: begin
        if (tmr_done_i) begin
          if (irq_pend_q || irq_i) begin
            state_d = ST_I2R; tmr_load_o = 1'b1; tmr_val_o = LD_IR;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_I2R:    if (tmr_done_i) state_d = ST_RUN;
      ST_TO_SLP: if (tmr_done_i) state_d = ST_SLEEP;
      ST_WAKE:   if (tmr_done_i) state_d = ST_RUN;
      default:   state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RUN;
      irq_pend_q <= 1'b0;
    end else begin
      state_q <= state_d;
      // interrupt seen during Idle entry is held until entry completes
      if (state_q == ST_R2I && !tmr_done_i) irq_pend_q <= irq_pend_q | irq_i;
      else                                  irq_pend_q <= 1'b0;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/pmode_acct.sv
module pmode_acct
  import pmode_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_MODES-1:0] settled_i,
  input  logic [1:0]           rd_addr_i,
  output logic [CNT_W-1:0]     rd_data_o
);
  logic [CNT_W-1:0] ctr_q [NUM_MODES];

  for (genvar g = 0; g < NUM_MODES; g++) begin : g_ctr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          ctr_q[g] <= '0;
      else if (settled_i[g] && ctr_q[g] != '1) ctr_q[g] <= ctr_q[g] + 1'b1;
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      2'd0:    rd_data_o = ctr_q[0];
      2'd1:    rd_data_o = ctr_q[1];
      2'd2:    rd_data_o = ctr_q[2];
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/pmode_ctrl.sv
module pmode_ctrl
  import pmode_pkg::*;
#(
  parameter int unsigned CNT_W           = 32,
  parameter int unsigned RUN_IDLE_LAT    = 4,
  parameter int unsigned IDLE_RUN_LAT    = 4,
  parameter int unsigned SLEEP_ENTRY_LAT = 8,
  parameter int unsigned SLEEP_EXIT_LAT  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             idle_req_i,
  input  logic             sleep_req_i,
  input  logic             irq_i,
  input  logic             wake_i,
  input  logic [1:0]       rd_addr_i,
  output logic             clk_gate_o,
  output logic             pwr_off_o,
  output logic             busy_o,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] rd_data_o
);
  localparam int unsigned MAX_A   = RUN_IDLE_LAT > IDLE_RUN_LAT ? RUN_IDLE_LAT : IDLE_RUN_LAT;
  localparam int unsigned MAX_B   = SLEEP_ENTRY_LAT > SLEEP_EXIT_LAT ? SLEEP_ENTRY_LAT : SLEEP_EXIT_LAT;
  localparam int unsigned MAX_LAT = MAX_A > MAX_B ? MAX_A : MAX_B;
  localparam int unsigned LAT_W   = $clog2(MAX_LAT + 1);

  pm_state_e              state;
  logic                   tmr_load, tmr_done;
  logic [LAT_W-1:0]       tmr_val;
  logic [NUM_MODES-1:0]   settled;

  pmode_fsm #(
    .LAT_W(LAT_W), .RUN_IDLE_LAT(RUN_IDLE_LAT), .IDLE_RUN_LAT(IDLE_RUN_LAT),
    .SLEEP_ENTRY_LAT(SLEEP_ENTRY_LAT), .SLEEP_EXIT_LAT(SLEEP_EXIT_LAT)
  ) u_fsm (
    .clk_i, .rst_ni, .idle_req_i, .sleep_req_i, .irq_i, .wake_i,
    .tmr_done_i(tmr_done), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .state_o(state)
  );

  pmode_lat_timer #(.LAT_W(LAT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val), .done_o(tmr_done)
  );

  assign settled = {state == ST_SLEEP, state == ST_IDLE, state == ST_RUN};

  pmode_acct #(.CNT_W(CNT_W)) u_acct (
    .clk_i, .rst_ni, .settled_i(settled), .rd_addr_i, .rd_data_o
  );

  always_comb begin
    clk_gate_o = (state != ST_RUN);   // released only once Run is settled
    pwr_off_o  = (state == ST_SLEEP); // cut only after entry latency
    busy_o     = ~|settled;
    unique case (state)
      ST_IDLE, ST_R2I:    mode_o = MODE_IDLE;
      ST_SLEEP, ST_TO_SLP: mode_o = MODE_SLEEP;
      default:            mode_o = MODE_RUN;
    endcase
  end
endmodule

// File: rtl/pmode_ctrl_chk.sv
module pmode_ctrl_chk #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wake_i,
  input logic [1:0]       rd_addr_i,
  input logic             clk_gate_o,
  input logic             pwr_off_o,
  input logic             busy_o,
  input logic [1:0]       mode_o,
  input logic [CNT_W-1:0] rd_data_o
);
  AST_PWR_NEEDS_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwr_off_o |-> clk_gate_o); // R2
  AST_RUN_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && mode_o == 2'd0) |-> (!clk_gate_o && !pwr_off_o)); // R2
  AST_MODE_VIA_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o)) |-> $stable(mode_o)); // R3
  AST_SLEEP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_off_o) |-> ($past(clk_gate_o) && $past(busy_o))); // R7
  AST_WAKE_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_gate_o) |-> ($past(busy_o) && !$past(pwr_off_o))); // R8
  AST_SLEEP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2 && !busy_o && !wake_i) |=> (mode_o == 2'd2 && !busy_o)); // R6
  AST_CNT_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(rd_addr_i) |-> (rd_data_o >= $past(rd_data_o))); // R10
  AST_SPARE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == 2'd3) |-> (rd_data_o == '0)); // R11
endmodule

bind pmode_ctrl pmode_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wake_i(wake_i), .rd_addr_i(rd_addr_i),
  .clk_gate_o(clk_gate_o), .pwr_off_o(pwr_off_o), .busy_o(busy_o),
  .mode_o(mode_o), .rd_data_o(rd_data_o)
);

// File: tb/pmode_ctrl_bench.sv
`timescale 1ns/1ps
module pmode_ctrl_bench;
  localparam int CW = 8;
  localparam int RI = 3, IR = 2, SE = 5, SX = 9;
  localparam int CMAX = (1 << CW) - 1;
  localparam int S_RUN = 0, S_IDLE = 1, S_SLP = 2, S_R2I = 3, S_I2R = 4, S_TS = 5, S_WK = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic idle_req = 0, sleep_req = 0, irq = 0, wake = 0;
  logic [1:0] rd_addr = 2'd0;
  logic gate, pwr, busy;
  logic [1:0] mode;
  logic [CW-1:0] rd_data;

  int total = 0, bad = 0;
  int ms, mc, mp;
  int ctr [3];
  bit chk_en = 0;

  always #4 clk = ~clk;

  pmode_ctrl #(.CNT_W(CW), .RUN_IDLE_LAT(RI), .IDLE_RUN_LAT(IR),
               .SLEEP_ENTRY_LAT(SE), .SLEEP_EXIT_LAT(SX)) u_pmode_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .idle_req_i(idle_req), .sleep_req_i(sleep_req),
    .irq_i(irq), .wake_i(wake), .rd_addr_i(rd_addr), .clk_gate_o(gate),
    .pwr_off_o(pwr), .busy_o(busy), .mode_o(mode), .rd_data_o(rd_data));

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int exp_mode(int s);
    if (s == S_IDLE || s == S_R2I) return 1;
    if (s == S_SLP || s == S_TS) return 2;
    return 0;
  endfunction

  // reference model built from the requirements
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = S_RUN; mc = 0; mp = 0;
      for (int i = 0; i < 3; i++) ctr[i] = 0;
    end else begin
      int nx, oc, op;
      nx = ms; oc = mc; op = mp;
      if (ms < 3 && ctr[ms] < CMAX) ctr[ms]++;
      mp = 0;
      case (ms)
        S_RUN:  if (sleep_req) begin nx = S_TS; mc = SE - 1; end
                else if (idle_req) begin nx = S_R2I; mc = RI - 1; end
        S_IDLE: if (irq) begin nx = S_I2R; mc = IR - 1; end
                else if (sleep_req) begin nx = S_TS; mc = SE - 1; end
        S_SLP:  if (wake) begin nx = S_WK; mc = SX - 1; end
        S_R2I: begin
          if (oc == 0) begin
            if (op != 0 || irq) begin nx = S_I2R; mc = IR - 1; end
            else nx = S_IDLE;
          end else begin
            mc = oc - 1; mp = (op != 0 || irq) ? 1 : 0;
          end
        end
        default: begin
          if (oc == 0) nx = (ms == S_TS) ? S_SLP : S_RUN;
          else mc = oc - 1;
        end
      endcase
      ms = nx;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      string et;
      et = (ms == S_TS) ? "R7" : (ms == S_WK) ? "R8" : "R2";
      chk("R3 mode", int'(mode), exp_mode(ms));
      chk("R3 busy", int'(busy), (ms >= 3) ? 1 : 0);
      chk({et, " gate"}, int'(gate), (ms != S_RUN) ? 1 : 0);
      chk({et, " pwr"}, int'(pwr), (ms == S_SLP) ? 1 : 0);
      chk("R10/R11 rd", int'(rd_data), (rd_addr < 3) ? ctr[rd_addr] : 0);
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle_bus();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog act=hung exp=finished");
    summary();
    $finish;
  end

  initial begin
    int n, idle_before;
    repeat (3) @(negedge clk);
    chk("R1 mode", int'(mode), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 gate", int'(gate), 0);
    chk("R1 pwr", int'(pwr), 0);
    chk("R1 ctr", int'(rd_data), 0);
    @(posedge clk); #1 rst_n = 1'b1; chk_en = 1;

    // R10 saturation and R11 spare address
    tick(300);
    @(negedge clk); chk("R10 sat", int'(rd_data), CMAX);
    tick(1); rd_addr = 2'd3;
    @(negedge clk); chk("R11 spare", int'(rd_data), 0);
    tick(1); rd_addr = 2'd0;

    // R3 sleep priority, latency
    idle_req = 1; sleep_req = 1; tick(1); idle_req = 0; sleep_req = 0;
    @(negedge clk); chk("R3 prio", int'(mode), 2);
    busy_len(n); chk("R3 sleep lat", n, SE);
    chk("R7 pwr settled", int'(pwr), 1);

    // R6 ignored events in Sleep
    tick(1); irq = 1; idle_req = 1; sleep_req = 1; tick(3);
    irq = 0; idle_req = 0; sleep_req = 0;
    @(negedge clk); chk("R6 stay mode", int'(mode), 2); chk("R6 stay busy", int'(busy), 0);
    tick(1); wake = 1; tick(1); wake = 0;
    @(negedge clk); chk("R8 pwr on", int'(pwr), 0); chk("R8 gate held", int'(gate), 1);
    busy_len(n); chk("R6 wake lat", n, SX);
    chk("R6 back run", int'(mode), 0);

    // R9 latched interrupt
    tick(1); rd_addr = 2'd1;
    @(negedge clk); idle_before = int'(rd_data);
    tick(1); idle_req = 1; tick(1); idle_req = 0; irq = 1; tick(1); irq = 0;
    @(negedge clk); busy_len(n); chk("R9 busy len", n + 1, RI + IR);
    chk("R9 run", int'(mode), 0);
    chk("R9 no idle", int'(rd_data), idle_before);

    // R5 irq beats sleep in Idle
    tick(1); idle_req = 1; tick(1); idle_req = 0;
    wait_idle_bus(); chk("R2 idle gate", int'(gate), 1); chk("R2 idle pwr", int'(pwr), 0);
    tick(1); irq = 1; sleep_req = 1; tick(1); irq = 0; sleep_req = 0;
    @(negedge clk); chk("R5 dest", int'(mode), 0); chk("R5 busy", int'(busy), 1);
    busy_len(n); chk("R5 lat", n, IR);

    // R4 requests dropped while busy, idle_req ignored in Idle
    tick(1); idle_req = 1; tick(1); idle_req = 0; sleep_req = 1; tick(1); sleep_req = 0;
    wait_idle_bus(); chk("R4 dropped", int'(mode), 1);
    tick(1); idle_req = 1; tick(2); idle_req = 0;
    @(negedge clk); chk("R4 idle req", int'(busy), 0);
    tick(1); irq = 1; tick(1); irq = 0;
    wait_idle_bus();

    // constrained random
    for (int k = 0; k < 3000; k++) begin
      tick(1);
      idle_req  = ($urandom_range(0, 99) < 10);
      sleep_req = ($urandom_range(0, 99) < 5);
      irq       = ($urandom_range(0, 99) < 8);
      wake      = ($urandom_range(0, 99) < 6);
      rd_addr   = 2'($urandom_range(0, 3));
    end
    tick(1); idle_req = 0; sleep_req = 0; irq = 0; wake = 0;
    tick(2);
    summary();
    $finish;
  end

  initial void'($urandom(32'h5eed_1234));
endmodule